// File: doc/BRIEF.md
# Multi-Queue FIFO Read Port

This block is the read side of a buffer that keeps up to 32 logical queues behind one shared output word. A simple push interface fills any queue. On the read side the block keeps an active-queue register. It takes the read address bus, an address strobe, a read enable and an output enable, and all of them are sampled on the rising clock edge. Every read is served from the active queue until a new queue is addressed.

The read address bus has two fields. The upper three bits are a device select, compared against a 3-bit identity input, and the low bits carry the queue number. Queue selection and reading are independent of each other. A read requested on the same edge as a new selection is still served from the queue that was active before that edge, so the output can deliver a word on every clock, including the edge where the queue changes. Two read modes exist. In standard mode a word is loaded into the output register by a read request. In fall-through mode the head word of the active queue is presented on its own, and a read request consumes it.

An 8-bit almost-empty status group reports one quadrant of eight queues, chosen by a 2-bit selector. The output enable is carried as a separate flag next to the data, so the block stays free of internal tri-states.

Top module: `mqr_read_port`

## Requirements
- R1: On a rising edge where rdAddrEn is 1 and rdAddr[7:5] equals devId, the active queue becomes rdAddr[4:0]. Every later read is served from that queue until another selection is accepted.
- R2: A selection whose rdAddr[7:5] differs from devId is ignored, and the active queue keeps its value. When rdAddrEn is 0 the active queue also holds.
- R3: rdEn has no effect on selection. A read requested on the selecting edge is served from the previously active queue, with no idle cycle.
- R4: In standard mode (fwftMode=0), an edge with rdEn=1 and a non-empty active queue loads that queue's head word into rdData. rdValid is then 1 for exactly the following cycle and 0 after any other edge.
- R5: A read of an empty active queue is blocked. rdValid stays 0, rdData keeps its value and no queue changes.
- R6: In fall-through mode (fwftMode=1), rdValid is 1 while the output register holds an unconsumed word. The word holds until an edge with rdEn=1 consumes it. On any edge where the register is empty or being consumed, the active queue's head word loads.
- R7: rdDataOe follows outEn with no clock delay. Loads into the output register happen the same way whatever the value of outEn.
- R8: aeStatus[b] is 1 exactly when queue quadSel*8+b holds AE_THRESH words or fewer. quadSel=0..3 covers queues 0-7, 8-15, 16-23 and 24-31.
- R9: wrEn=1 appends wrData to queue wrQueue. If that queue already holds QUEUE_DEPTH words at the edge, the write is dropped.
- R10: After reset, rdValid=0, rdData=0, every queue is empty, aeStatus=8'hFF and queue 0 is active.
- R11: Each queue returns its words in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read and write clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fwftMode | input | 1 | 0 = standard read, 1 = fall-through read |
| devId | input | 3 | Identity compared with rdAddr[7:5] |
| rdAddr | input | 8 | Device select [7:5], queue number [4:0] |
| rdAddrEn | input | 1 | Queue selection strobe |
| rdEn | input | 1 | Read request |
| outEn | input | 1 | Output enable |
| quadSel | input | 2 | Quadrant shown on aeStatus |
| wrEn | input | 1 | Push strobe |
| wrQueue | input | 5 | Queue written by a push |
| wrData | input | DATA_W | Word pushed |
| rdData | output | DATA_W | Output register |
| rdDataOe | output | 1 | Drive-enable flag for rdData |
| rdValid | output | 1 | Output word status (see R4, R6) |
| aeStatus | output | 8 | Almost-empty flags of the chosen quadrant |

## Verification
The assertions take fwftMode to be constant outside reset. They also take devId to be stable, and every input to settle between clock edges, because the mode-dependent properties read fwftMode on both sides of an implication. The bench changes the mode only while reset is held, keeps devId fixed, and drives every input a short time after the rising edge. Its random phase mixes matching and mismatching device selects, reads of empty queues and writes to full queues, and keeps all of them legal inputs under these terms.

// File: rtl/mqr_pkg.sv
package mqr_pkg;

  localparam int ADDR_W = 8;
  localparam int ID_W   = 3;
  localparam int STAT_W = 8;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rdMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic popEn;    // remove head of active queue
    logic loadOut;  // capture head word into output register
  } rdStrobe_t;

endpackage

// File: rtl/mqr_queue.sv
module mqr_queue #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] headData,
  output logic              empty,
  output logic              full,
  output logic [$clog2(DEPTH+1)-1:0] fill
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = mem[rdPtr];
  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign fill     = count;

endmodule

// File: rtl/mqr_ctrl.sv
module mqr_ctrl
  import mqr_pkg::*;
#(
  parameter int NUM_QUEUES = 32,
  localparam int QW = $clog2(NUM_QUEUES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  fwftMode,
  input  logic [ID_W-1:0]       devId,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic                  rdAddrEn,
  input  logic                  rdEn,
  input  logic [NUM_QUEUES-1:0] emptyVec,
  output logic [QW-1:0]         actQ,
  output rdStrobe_t             strobe,
  output logic                  outValid
);

  rdMode_t mode;
  logic    idHit;
  logic    headEmpty;
  logic    take;
  logic    validNext;

  assign mode      = rdMode_t'(fwftMode);
  assign idHit     = (rdAddr[ADDR_W-1 -: ID_W] == devId);
  assign headEmpty = emptyVec[actQ];

  always_comb begin
    take      = 1'b0;
    validNext = 1'b0;
    unique case (mode)
      MODE_STD: begin
        take      = rdEn && !headEmpty;
        validNext = take;
      end
      MODE_FWFT: begin
        take      = (!outValid || rdEn) && !headEmpty;
        validNext = take || (outValid && !rdEn);
      end
    endcase
    strobe.popEn   = take;
    strobe.loadOut = take;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actQ     <= '0;
      outValid <= 1'b0;
    end else begin
      if (rdAddrEn && idHit) actQ <= rdAddr[QW-1:0];
      outValid <= validNext;
    end
  end

endmodule

// File: rtl/mqr_store.sv
module mqr_store
  import mqr_pkg::*;
#(
  parameter int NUM_QUEUES  = 32,
  parameter int DATA_W      = 16,
  parameter int QUEUE_DEPTH = 8,
  parameter int AE_THRESH   = 2,
  localparam int QW = $clog2(NUM_QUEUES),
  localparam int CW = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [QW-1:0]         wrQueue,
  input  logic [DATA_W-1:0]     wrData,
  input  rdStrobe_t             strobe,
  input  logic [QW-1:0]         actQ,
  input  logic [1:0]            quadSel,
  output logic [NUM_QUEUES-1:0] emptyVec,
  output logic [DATA_W-1:0]     outData,
  output logic [STAT_W-1:0]     aeStatus
);

  logic [DATA_W-1:0] heads  [NUM_QUEUES];
  logic [CW-1:0]     counts [NUM_QUEUES];
  logic [NUM_QUEUES-1:0] fullVec;

  for (genvar qi = 0; qi < NUM_QUEUES; qi++) begin : g_queue
    logic pushHere, popHere;
    assign pushHere = wrEn && (wrQueue == QW'(qi)) && !fullVec[qi];
    assign popHere  = strobe.popEn && (actQ == QW'(qi));
    mqr_queue #(
      .DATA_W(DATA_W),
      .DEPTH (QUEUE_DEPTH)
    ) u_q (
      .clk     (clk),
      .rstN    (rstN),
      .push    (pushHere),
      .pushData(wrData),
      .pop     (popHere),
      .headData(heads[qi]),
      .empty   (emptyVec[qi]),
      .full    (fullVec[qi]),
      .fill    (counts[qi])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               outData <= '0;
    else if (strobe.loadOut) outData <= heads[actQ];
  end

  always_comb begin
    for (int b = 0; b < STAT_W; b++) begin
      logic [4:0] qIdx;
      qIdx = {quadSel, b[2:0]};
      if (32'(qIdx) < NUM_QUEUES)
        aeStatus[b] = (counts[qIdx[QW-1:0]] <= CW'(AE_THRESH));
      else
        aeStatus[b] = 1'b1;
    end
  end

endmodule

// File: rtl/mqr_read_port.sv
module mqr_read_port
  import mqr_pkg::*;
#(
  parameter int NUM_QUEUES  = 32,
  parameter int DATA_W      = 16,
  parameter int QUEUE_DEPTH = 8,
  parameter int AE_THRESH   = 2,
  localparam int QW = $clog2(NUM_QUEUES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fwftMode,
  input  logic [2:0]        devId,
  input  logic [7:0]        rdAddr,
  input  logic              rdAddrEn,
  input  logic              rdEn,
  input  logic              outEn,
  input  logic [1:0]        quadSel,
  input  logic              wrEn,
  input  logic [QW-1:0]     wrQueue,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDataOe,
  output logic              rdValid,
  output logic [7:0]        aeStatus
);

  logic [QW-1:0]         actQ;
  logic [NUM_QUEUES-1:0] emptyVec;
  rdStrobe_t             strobe;

  mqr_ctrl #(.NUM_QUEUES(NUM_QUEUES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .fwftMode(fwftMode),
    .devId   (devId),
    .rdAddr  (rdAddr),
    .rdAddrEn(rdAddrEn),
    .rdEn    (rdEn),
    .emptyVec(emptyVec),
    .actQ    (actQ),
    .strobe  (strobe),
    .outValid(rdValid)
  );

  mqr_store #(
    .NUM_QUEUES (NUM_QUEUES),
    .DATA_W     (DATA_W),
    .QUEUE_DEPTH(QUEUE_DEPTH),
    .AE_THRESH  (AE_THRESH)
  ) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrQueue (wrQueue),
    .wrData  (wrData),
    .strobe  (strobe),
    .actQ    (actQ),
    .quadSel (quadSel),
    .emptyVec(emptyVec),
    .outData (rdData),
    .aeStatus(aeStatus)
  );

  assign rdDataOe = outEn;

endmodule

// File: rtl/mqr_read_port_chk.sv
module mqr_read_port_chk #(
  parameter int NUM_QUEUES = 32,
  parameter int DATA_W     = 16,
  localparam int QW = $clog2(NUM_QUEUES)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  fwftMode,
  input logic [2:0]            devId,
  input logic [7:0]            rdAddr,
  input logic                  rdAddrEn,
  input logic                  rdEn,
  input logic                  rdValid,
  input logic [DATA_W-1:0]     rdData,
  input logic [QW-1:0]         actQ,
  input logic [NUM_QUEUES-1:0] emptyVec
);

  // R1
  sel_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrEn && rdAddr[7:5] == devId) |=> (actQ == $past(rdAddr[QW-1:0])));

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdAddrEn && rdAddr[7:5] == devId) |=> $stable(actQ));

  // R5
  empty_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fwftMode && rdEn && emptyVec[actQ]) |=> (!rdValid && $stable(rdData)));

  // R4
  std_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fwftMode && !rdEn) |=> !rdValid);

  // R6
  fwft_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwftMode && rdValid && !rdEn) |=> (rdValid && $stable(rdData)));

endmodule

bind mqr_read_port mqr_read_port_chk #(
  .NUM_QUEUES(NUM_QUEUES),
  .DATA_W    (DATA_W)
) u_chk (.*);

// File: tb/sim_mqr_read_port.sv
module sim_mqr_read_port;

  localparam int NQ    = 32;
  localparam int DW    = 16;
  localparam int DEPTH = 8;
  localparam int AETH  = 2;
  localparam logic [2:0] DEVID = 3'd5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          fwftMode = 1'b0;
  logic [2:0]    devId = DEVID;
  logic [7:0]    rdAddr = '0;
  logic          rdAddrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic          outEn = 1'b1;
  logic [1:0]    quadSel = '0;
  logic          wrEn = 1'b0;
  logic [4:0]    wrQueue = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          rdDataOe;
  logic          rdValid;
  logic [7:0]    aeStatus;

  always #5 clk = ~clk;

  mqr_read_port #(
    .NUM_QUEUES(NQ), .DATA_W(DW), .QUEUE_DEPTH(DEPTH), .AE_THRESH(AETH)
  ) u0 (
    .clk(clk), .rstN(rstN), .fwftMode(fwftMode), .devId(devId),
    .rdAddr(rdAddr), .rdAddrEn(rdAddrEn), .rdEn(rdEn), .outEn(outEn),
    .quadSel(quadSel), .wrEn(wrEn), .wrQueue(wrQueue), .wrData(wrData),
    .rdData(rdData), .rdDataOe(rdDataOe), .rdValid(rdValid), .aeStatus(aeStatus)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: per-queue contents, active queue, output state
  logic [DW-1:0] refQ [NQ][$];
  logic [DW-1:0] expQ [$];
  int  mAct  = 0;
  bit  mVal  = 0;
  bit  mFull = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < NQ; q++) refQ[q].delete();
      expQ.delete();
      mAct = 0; mVal = 0; mFull = 0;
    end else begin
      bit wrOk, nonEmpty, take;
      wrOk     = wrEn && (refQ[wrQueue].size() < DEPTH);   // R9
      nonEmpty = refQ[mAct].size() > 0;                      // R5
      if (!fwftMode) begin
        take = rdEn && nonEmpty;                             // R4
        mVal = take;
      end else begin
        take  = (!mFull || rdEn) && nonEmpty;                // R6
        mFull = take || (mFull && !rdEn);
      end
      if (take) expQ.push_back(refQ[mAct].pop_front());      // R3: old queue
      if (rdAddrEn && rdAddr[7:5] == devId) mAct = int'(rdAddr[4:0]); // R1 R2
      if (wrOk) refQ[wrQueue].push_back(wrData);
    end
  end

  // monitor: pops expected words and compares
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [7:0] expAe;
      chk(rdDataOe === outEn, "R7 oe flag", 32'(rdDataOe), 32'(outEn));
      for (int b = 0; b < 8; b++)
        expAe[b] = refQ[int'(quadSel) * 8 + b].size() <= AETH;
      chk(aeStatus === expAe, "R8 status", 32'(aeStatus), 32'(expAe));
      if (!fwftMode) begin
        chk(rdValid === mVal, "R4 valid", 32'(rdValid), 32'(mVal));
        if (mVal && expQ.size() > 0) begin
          logic [DW-1:0] e;
          e = expQ.pop_front();
          chk(rdData === e, "R11 std order", 32'(rdData), 32'(e));
        end
      end else begin
        chk(rdValid === mFull, "R6 valid", 32'(rdValid), 32'(mFull));
        if (mFull && expQ.size() > 0) begin
          chk(rdData === expQ[0], "R11 fwft order", 32'(rdData), 32'(expQ[0]));
          if (rdEn) void'(expQ.pop_front());
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic doReset(input bit m);
    rstN = 0; fwftMode = m;
    wrEn = 0; rdEn = 0; rdAddrEn = 0; outEn = 1; quadSel = 0;
    repeat (3) cyc();
    rstN = 1;
  endtask

  task automatic put(input int q, input logic [DW-1:0] d);
    wrEn = 1; wrQueue = 5'(q); wrData = d;
    cyc();
    wrEn = 0;
  endtask

  task automatic sel(input int q, input logic [2:0] id, input bit re);
    rdAddrEn = 1; rdAddr = {id, 5'(q)}; rdEn = re;
    cyc();
    rdAddrEn = 0; rdEn = 0;
  endtask

  task automatic rd(input int n);
    rdEn = 1;
    repeat (n) cyc();
    rdEn = 0;
  endtask

  task automatic fill();
    for (int i = 0; i < 4; i++) put(3, 16'h3000 + 16'(i));
    for (int i = 0; i < 3; i++) put(5, 16'h5000 + 16'(i));
    for (int i = 0; i < 9; i++) put(7, 16'h7000 + 16'(i));   // R9: ninth dropped
    for (int i = 0; i < 2; i++) put(12, 16'hC000 + 16'(i));
    for (int i = 0; i < 5; i++) put(20, 16'h4000 + 16'(i));
  endtask

  task automatic randomPhase(input int n);
    for (int k = 0; k < n; k++) begin
      wrEn    = ($urandom_range(0, 2) != 0);
      wrQueue = ($urandom_range(0, 7) == 0) ? 5'($urandom_range(0, 31)) : 5'($urandom_range(0, 3));
      wrData  = 16'($urandom);
      rdEn    = ($urandom_range(0, 1) == 1);
      outEn   = ($urandom_range(0, 3) != 0);
      quadSel = 2'($urandom_range(0, 3));
      rdAddrEn = ($urandom_range(0, 7) == 0);
      rdAddr  = {(($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : DEVID),
                 (($urandom_range(0, 7) == 0) ? 5'($urandom_range(0, 31)) : 5'($urandom_range(0, 3)))};
      cyc();
    end
    wrEn = 0; rdEn = 0; rdAddrEn = 0; outEn = 1;
  endtask

  initial begin
    logic [DW-1:0] hold;

    // ---------- standard mode ----------
    doReset(0);
    // R10
    chk(rdValid === 1'b0, "R10 valid", 32'(rdValid), 0);
    chk(rdData === '0, "R10 data", 32'(rdData), 0);
    chk(aeStatus === 8'hFF, "R10 status", 32'(aeStatus), 32'hFF);

    fill();
    quadSel = 0; #1;
    chk(aeStatus === 8'h57, "R8 quad0", 32'(aeStatus), 32'h57);
    quadSel = 1; #1;
    chk(aeStatus === 8'hFF, "R8 quad1", 32'(aeStatus), 32'hFF);
    quadSel = 2; #1;
    chk(aeStatus === 8'hEF, "R8 quad2", 32'(aeStatus), 32'hEF);
    quadSel = 0;

    sel(3, DEVID, 0);
    rd(2);
    chk(rdData === 16'h3001, "R4 second word", 32'(rdData), 32'h3001);
    sel(5, DEVID, 1);                     // read on selecting edge
    chk(rdData === 16'h3002, "R3 no bubble", 32'(rdData), 32'h3002);
    rd(1);
    chk(rdData === 16'h5000, "R1 new queue", 32'(rdData), 32'h5000);
    rd(2);
    hold = rdData;
    rd(1);                                 // q5 now empty
    chk(!rdValid && rdData === hold, "R5 empty read", 32'(rdData), 32'(hold));

    sel(7, DEVID ^ 3'd1, 0);               // wrong device id
    rd(1);
    chk(rdValid === 1'b0, "R2 id mismatch", 32'(rdValid), 0);
    sel(7, DEVID, 0);
    rd(1);
    chk(rdData === 16'h7000, "R1 queue 7", 32'(rdData), 32'h7000);
    outEn = 0;
    rd(1);
    chk(rdDataOe === 1'b0 && rdData === 16'h7001, "R7 load while disabled", 32'(rdData), 32'h7001);
    outEn = 1; #1;
    chk(rdDataOe === 1'b1, "R7 enable", 32'(rdDataOe), 1);
    rd(7);
    chk(rdValid === 1'b0 && rdData === 16'h7007, "R9 full drop", 32'(rdData), 32'h7007);

    randomPhase(3000);
    chk(expQ.size() == 0, "R11 std drain", 32'(expQ.size()), 0);

    // ---------- fall-through mode ----------
    doReset(1);
    chk(rdValid === 1'b0 && rdData === '0, "R10 fwft reset", 32'(rdData), 0);
    fill();
    sel(3, DEVID, 0);
    cyc();
    chk(rdValid === 1'b1 && rdData === 16'h3000, "R6 head shown", 32'(rdData), 32'h3000);
    repeat (3) cyc();
    chk(rdValid === 1'b1 && rdData === 16'h3000, "R6 head held", 32'(rdData), 32'h3000);
    rd(1);
    chk(rdData === 16'h3001, "R6 consume", 32'(rdData), 32'h3001);
    sel(5, DEVID, 1);
    chk(rdData === 16'h3002, "R3 fwft switch", 32'(rdData), 32'h3002);
    rd(1);
    chk(rdData === 16'h5000, "R1 fwft new queue", 32'(rdData), 32'h5000);
    rd(3);
    chk(rdValid === 1'b0, "R5 fwft drained", 32'(rdValid), 0);

    randomPhase(3000);
    chk(expQ.size() == (mFull ? 1 : 0), "R11 fwft drain", 32'(expQ.size()), 32'(mFull));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule